// File: doc/BRIEF.md
# Vector Table Fetch Sequencer

This block brings a processor core out of reset and into exception handlers by reading addresses from a vector table in memory. As soon as reset is released it performs two reads: the word at the start of the table becomes the initial main stack pointer, and the word after it becomes the starting program counter. Later, whenever the core accepts an exception, the block reads the handler address for that exception number and loads it into the program counter.

The table base lives in a register that starts at address zero and may be moved by software to any 128-byte aligned address. Every fetched handler address has to carry a set least significant bit, which marks the compact instruction state. The program counter receives the address with that bit cleared. An entry whose bit 0 is clear raises a fault pulse and does not change the program counter.

Memory reads go through a simple request/ready port with a separate response valid. Only one read is in flight at a time.

Top module: `vecfetch_seq`

## Requirements
- R1: After reset is released, the first read is issued at address base + 0, with the base at 0x00000000. Its response is loaded into `sp_out` with bits [1:0] forced to zero.
- R2: The second boot read is at base + 4. If bit 0 of the response is 1, `pc_out` takes the response with bit 0 cleared and `done` pulses.
- R3: If bit 0 of a fetched vector (boot or exception) is 0, `fault` pulses for one cycle, `done` stays low, `pc_out` keeps its previous value, and the block returns to idle.
- R4: The table base resets to 0x00000000. A write through `base_we` stores `base_wdata` with bits [6:0] cleared. The new base is used by every fetch issued after the write. Bits [6:0] of the written data have no effect on any fetch address.
- R5: An exception request (`exc_req` high for a cycle) while idle causes exactly one read, at base + 4·`exc_num` (modulo 2^32). The result is handled as in R2 or R3.
- R6: `busy` is high from reset until the boot sequence ends, and from an accepted request until its fetch ends. An `exc_req` raised while `busy` is high is ignored.
- R7: `rd_req` stays high with a stable `rd_addr` until `rd_ready` is seen. At most one read is outstanding. `rsp_valid` is used only while a granted read waits for its data, and is ignored at all other times.
- R8: `done` is never high for two consecutive cycles, and `done` and `fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Table base write strobe |
| base_wdata | input | 32 | New table base (low 7 bits dropped) |
| exc_req | input | 1 | Request a handler fetch |
| exc_num | input | 8 | Exception number for the fetch |
| rd_req | output | 1 | Read request valid |
| rd_addr | output | 32 | Read word address |
| rd_ready | input | 1 | Memory accepts the request |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data |
| sp_out | output | 32 | Loaded main stack pointer |
| pc_out | output | 32 | Loaded program counter |
| done | output | 1 | One-cycle pulse: program counter loaded |
| fault | output | 1 | One-cycle pulse: vector with bit 0 clear |
| busy | output | 1 | A fetch sequence is in progress |

## Verification
The assertions assume that the memory side obeys the port protocol. A response arrives only after its request has been granted, and `rd_ready` is raised only while `rd_req` is high. The bench responder waits for `rd_req`, stalls the grant for a random zero to two cycles, and returns exactly one response after a further random zero to two cycles. It drives stray `rsp_valid` only while the block is idle. Base writes and exception requests are issued only while the memory port is quiet, with the exception of the deliberate requests sent during `busy`.

// File: rtl/vf_pkg.sv
package vf_pkg;
  typedef enum logic [1:0] {
    ST_BOOT_SP = 2'd0,
    ST_BOOT_PC = 2'd1,
    ST_IDLE    = 2'd2,
    ST_EXC     = 2'd3
  } vf_state_e;

  typedef enum logic [1:0] {
    PT_IDLE = 2'd0,
    PT_REQ  = 2'd1,
    PT_WAIT = 2'd2
  } vf_port_e;
endpackage

// File: rtl/vf_base_reg.sv
module vf_base_reg #(
  parameter int AW    = 32,
  parameter int ALIGN = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] base
);
  localparam logic [AW-1:0] KEEP = {AW{1'b1}} << ALIGN;

  function automatic logic [AW-1:0] align_base(input logic [AW-1:0] v);
    return v & KEEP;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base <= '0;
    else if (wr_en) base <= align_base(wr_data);
  end
endmodule

// File: rtl/vf_rd_port.sv
module vf_rd_port
  import vf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ready,
  input  logic          rsp_valid,
  input  logic [AW-1:0] rsp_data,
  output logic          idle,
  output logic          got,
  output logic [AW-1:0] got_data
);
  vf_port_e      p_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q    <= PT_IDLE;
      addr_q <= '0;
    end else begin
      case (p_q)
        PT_IDLE: if (start) begin
          p_q    <= PT_REQ;
          addr_q <= start_addr;
        end
        PT_REQ:  if (rd_ready) p_q <= PT_WAIT;
        PT_WAIT: if (rsp_valid) p_q <= PT_IDLE;
        default: p_q <= PT_IDLE;
      endcase
    end
  end

  assign rd_req   = (p_q == PT_REQ);
  assign rd_addr  = addr_q;
  assign idle     = (p_q == PT_IDLE);
  assign got      = (p_q == PT_WAIT) && rsp_valid;
  assign got_data = rsp_data;

  // R7: request held with a stable address until it is accepted
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));

  // R7: a new read is only launched when none is outstanding
  a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> idle);
endmodule

// File: rtl/vf_ctrl.sv
module vf_ctrl
  import vf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    base,
  input  logic             exc_req,
  input  logic [NUM_W-1:0] exc_num,
  input  logic             port_idle,
  input  logic             got,
  input  logic [AW-1:0]    got_data,
  output logic             start,
  output logic [AW-1:0]    start_addr,
  output logic [AW-1:0]    sp,
  output logic [AW-1:0]    pc,
  output logic             done,
  output logic             fault,
  output logic             busy
);
  vf_state_e        state_q;
  logic             issued_q;
  logic [NUM_W-1:0] num_q;
  logic [NUM_W-1:0] idx;

  function automatic logic [AW-1:0] vec_addr(input logic [AW-1:0] b,
                                             input logic [NUM_W-1:0] n);
    return b + (AW'(n) << 2);
  endfunction

  function automatic logic [AW-1:0] align_sp(input logic [AW-1:0] w);
    return {w[AW-1:2], 2'b00};
  endfunction

  function automatic logic [AW-1:0] strip_state(input logic [AW-1:0] w);
    return {w[AW-1:1], 1'b0};
  endfunction

  always_comb begin
    case (state_q)
      ST_BOOT_PC: idx = NUM_W'(1);
      ST_EXC:     idx = num_q;
      default:    idx = '0;
    endcase
  end

  assign start_addr = vec_addr(base, idx);
  assign start      = (state_q != ST_IDLE) && !issued_q;
  assign busy       = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_BOOT_SP;
      issued_q <= 1'b0;
      num_q    <= '0;
      sp       <= '0;
      pc       <= '0;
      done     <= 1'b0;
      fault    <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (start) issued_q <= 1'b1;
      case (state_q)
        ST_BOOT_SP: if (got) begin
          sp       <= align_sp(got_data);
          state_q  <= ST_BOOT_PC;
          issued_q <= 1'b0;
        end
        ST_BOOT_PC, ST_EXC: if (got) begin
          if (got_data[0]) begin
            pc   <= strip_state(got_data);
            done <= 1'b1;
          end else begin
            fault <= 1'b1;
          end
          state_q  <= ST_IDLE;
          issued_q <= 1'b0;
        end
        ST_IDLE: if (exc_req) begin
          num_q   <= exc_num;
          state_q <= ST_EXC;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: outcome pulses are exclusive
  a_r8_done_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  // R8: done lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: a faulting vector leaves the program counter alone
  a_r3_fault_keeps_pc: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (pc == $past(pc)));

  // R6: when idle the memory port has nothing outstanding
  a_r6_idle_port_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> port_idle);
endmodule

// File: rtl/vecfetch_seq.sv
module vecfetch_seq #(
  parameter int AW    = 32,
  parameter int NUM_W = 8,
  parameter int ALIGN = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [AW-1:0]    base_wdata,
  input  logic             exc_req,
  input  logic [NUM_W-1:0] exc_num,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_ready,
  input  logic             rsp_valid,
  input  logic [AW-1:0]    rsp_data,
  output logic [AW-1:0]    sp_out,
  output logic [AW-1:0]    pc_out,
  output logic             done,
  output logic             fault,
  output logic             busy
);
  logic [AW-1:0] base;
  logic          start;
  logic [AW-1:0] start_addr;
  logic          port_idle;
  logic          got;
  logic [AW-1:0] got_data;

  vf_base_reg #(.AW(AW), .ALIGN(ALIGN)) u_base (
    .clk(clk), .rst_n(rst_n), .wr_en(base_we), .wr_data(base_wdata), .base(base)
  );

  vf_rd_port #(.AW(AW)) u_port (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .idle(port_idle), .got(got), .got_data(got_data)
  );

  vf_ctrl #(.AW(AW), .NUM_W(NUM_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .base(base), .exc_req(exc_req), .exc_num(exc_num),
    .port_idle(port_idle), .got(got), .got_data(got_data),
    .start(start), .start_addr(start_addr), .sp(sp_out), .pc(pc_out),
    .done(done), .fault(fault), .busy(busy)
  );
endmodule

// File: tb/vecfetch_seq_tb.sv
module vecfetch_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        exc_req = 1'b0;
  logic [7:0]  exc_num = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic [31:0] sp_out, pc_out;
  logic        done, fault, busy;

  always #10 clk = ~clk;

  vecfetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .exc_req(exc_req), .exc_num(exc_num), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .sp_out(sp_out), .pc_out(pc_out), .done(done), .fault(fault), .busy(busy)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int done_cnt = 0;
  int fault_cnt = 0;
  int grant_cnt = 0;
  bit prev_done = 1'b0;
  bit wide_bad = 1'b0;
  bit both_bad = 1'b0;
  bit hold_bad = 1'b0;
  logic [31:0] last_addr = '0;
  logic [31:0] tbl [logic [31:0]];
  logic [31:0] model_base = '0;

  function automatic logic [31:0] word_at(input logic [31:0] a);
    if (tbl.exists(a)) return tbl[a];
    return {a[15:0], a[15:0]} | 32'h1;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input int n);
    return b + 32'(n * 4);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) begin
        logic [31:0] first_a;
        first_a = rd_addr;
        repeat ($urandom_range(2, 0)) begin
          @(negedge clk);
          if (!(rd_req && rd_addr == first_a)) hold_bad = 1'b1;
        end
        rd_ready  = 1'b1;
        last_addr = rd_addr;
        grant_cnt++;
        @(negedge clk);
        rd_ready = 1'b0;
        repeat ($urandom_range(2, 0)) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_data  = word_at(last_addr);
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  // output pulse monitor
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (fault) fault_cnt++;
    if (done && fault) both_bad = 1'b1;
    if (done && prev_done) wide_bad = 1'b1;
    prev_done = done;
  end

  task automatic wait_end();
    int s;
    s = done_cnt + fault_cnt;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done_cnt + fault_cnt != s) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic do_exc(input int n);
    @(negedge clk);
    exc_req = 1'b1;
    exc_num = 8'(n);
    @(negedge clk);
    exc_req = 1'b0;
    wait_end();
  endtask

  task automatic write_base(input logic [31:0] v);
    @(negedge clk);
    base_we = 1'b1;
    base_wdata = v;
    model_base = v & 32'hFFFF_FF80;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic exc_and_check(input int n, input logic [31:0] val, input string tag);
    logic [31:0] a, pc0;
    int d0, f0, g0;
    a = exp_addr(model_base, n);
    tbl[a] = val;
    pc0 = pc_out; d0 = done_cnt; f0 = fault_cnt; g0 = grant_cnt;
    do_exc(n);
    check(last_addr == a && grant_cnt == g0 + 1, tag, last_addr, a);
    if (val[0]) begin
      check(pc_out == (val & 32'hFFFF_FFFE) && done_cnt == d0 + 1, tag, pc_out,
            val & 32'hFFFF_FFFE);
    end else begin
      check(pc_out == pc0 && fault_cnt == f0 + 1 && done_cnt == d0, tag, pc_out, pc0);
    end
    check(busy == 1'b0, tag, 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    tbl[32'h0] = 32'h2000_8003;
    tbl[32'h4] = 32'h0000_0101;
    repeat (3) @(negedge clk);
    check(rd_req == 0 && done == 0 && fault == 0, "R6 reset outputs", {29'd0, rd_req, done, fault}, 32'd0);
    check(sp_out == 0 && pc_out == 0, "R1 reset sp/pc", sp_out | pc_out, 32'd0);
    check(busy == 1'b1, "R6 busy in reset", 32'(busy), 32'd1);
    rst_n = 1'b1;

    // boot: two reads
    wait_end();
    check(grant_cnt == 2, "R2 boot read count", 32'(grant_cnt), 32'd2);
    check(sp_out == 32'h2000_8000, "R1 sp aligned", sp_out, 32'h2000_8000);
    check(last_addr == 32'h4, "R2 reset vector address", last_addr, 32'h4);
    check(pc_out == 32'h0000_0100 && done_cnt == 1, "R2 pc loaded", pc_out, 32'h100);
    check(busy == 1'b0, "R6 idle after boot", 32'(busy), 32'd0);

    // exceptions at base 0
    exc_and_check(3, 32'h0000_2345, "R5 exc 3");
    exc_and_check(0, 32'h0000_0401, "R5 exc 0");

    // base move ignoring low bits
    write_base(32'h0000_12FF);
    exc_and_check(0, 32'h0000_5001, "R4 base low bits dropped");
    exc_and_check(255, 32'hABCD_0007, "R5 exc 255");

    // fault vector
    exc_and_check(17, 32'h0000_6000, "R3 clear state bit");

    // wrap-around of the address sum
    write_base(32'hFFFF_FF80);
    exc_and_check(40, 32'h0000_7777, "R5 address wraps");

    // request while busy is ignored
    begin
      int g0;
      logic [31:0] a;
      write_base(32'h0000_0200);
      a = exp_addr(model_base, 5);
      tbl[a] = 32'h0000_0811;
      g0 = grant_cnt;
      @(negedge clk);
      exc_req = 1'b1; exc_num = 8'd5;
      @(negedge clk);
      exc_num = 8'd9;
      repeat (2) @(negedge clk);
      exc_req = 1'b0;
      wait_end();
      repeat (5) @(negedge clk);
      check(grant_cnt == g0 + 1, "R6 request while busy ignored", 32'(grant_cnt), 32'(g0 + 1));
      check(last_addr == a && pc_out == 32'h0000_0810, "R6 only first request served", last_addr, a);
    end

    // stray response while idle
    begin
      logic [31:0] pc0;
      int d0, f0;
      pc0 = pc_out; d0 = done_cnt; f0 = fault_cnt;
      @(negedge clk);
      rsp_valid = 1'b1; rsp_data = 32'h0000_9991;
      @(negedge clk);
      rsp_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(pc_out == pc0 && done_cnt == d0 && fault_cnt == f0 && !busy,
            "R7 stray response ignored", pc_out, pc0);
    end

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [31:0] v;
      if ($urandom_range(3, 0) == 0) write_base($urandom);
      v = $urandom;
      v[0] = ($urandom_range(4, 0) != 0);
      exc_and_check($urandom_range(255, 0), v, "R5 random fetch");
    end

    check(!wide_bad && !both_bad, "R8 done pulse shape", {30'd0, wide_bad, both_bad}, 32'd0);
    check(!hold_bad, "R7 request held stable", 32'(hold_bad), 32'd0);

    // second reset: base returns to zero, boot vector faults
    write_base(32'h0000_4000);
    tbl[32'h4] = 32'h0000_0300;
    tbl[32'h0] = 32'h1000_0FFE;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_base = '0;
    begin
      int f0, d0;
      f0 = fault_cnt; d0 = done_cnt;
      wait_end();
      check(last_addr == 32'h4, "R4 base reset to zero", last_addr, 32'h4);
      check(sp_out == 32'h1000_0FFC, "R1 sp bits cleared", sp_out, 32'h1000_0FFC);
      check(fault_cnt == f0 + 1 && done_cnt == d0 && pc_out == 32'h0,
            "R3 boot vector fault", pc_out, 32'h0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule